// File: doc/BRIEF.md
# Packed Float32 Special-Value Fixup Unit

This block repairs special floating-point results lane by lane across a vector of single-precision elements. It does no arithmetic. Each lane sorts its source element into one of eight categories: quiet NaN, signaling NaN, zero, exactly +1.0, negative infinity, positive infinity, other negative and other positive. The lane's own 32-bit table word holds one 4-bit response code per category. The category picks a code, and the code names the replacement value. Replacements include copies of either operand, NaNs, infinities, signed zeros, a few fixed constants and the largest finite value. A typical use follows a reciprocal or square-root approximation sequence. There it forces the architecturally correct result for inputs such as zero or infinity.

A per-lane write mask decides which lanes are updated. A lane with mask bit 0 either keeps its destination element or, under zero-masking, is written with +0.0. A response code of zero also keeps the destination element. An 8-bit control immediate enables reporting of divide-by-zero and invalid conditions. These are gathered over the active lanes into two sticky flags, and the block never traps. An optional broadcast mode uses a single table word for every lane. The lanes are combinational. Results and flags are registered when an input strobe is seen, so outputs appear one clock later.

Top module: `fp32_fixup_unit`

## Requirements
- R1: The source element is classified as follows, and token t selects table bits [4t+3:4t]. Token 0 is a quiet NaN: exponent all ones, fraction nonzero, fraction bit 22 set. Token 1 is a signaling NaN: exponent all ones, fraction nonzero, bit 22 clear. Token 2 is zero of either sign. Token 3 is exactly 0x3F800000. Token 4 is 0xFF800000 and token 5 is 0x7F800000. Token 6 is any other value with the sign set, and token 7 is any other value with the sign clear.
- R2: An active lane whose selected code is 0 outputs its destination element unchanged.
- R3: Codes 1 to 15 give, in order: the destination element; the source element; the source with fraction bit 22 set; 0x7FC00000; 0xFF800000; 0x7F800000; an infinity carrying the source sign; 0x80000000; 0x00000000; 0xBF800000; 0x3F800000; 0x3F000000; 0x42B40000; 0x3FC90FDB; and the source sign joined to 0x7F7FFFFF.
- R4: A lane with write-mask bit 0 and zero-masking off outputs its destination element.
- R5: A lane with write-mask bit 0 and zero-masking on outputs 0x00000000.
- R6: With denormals-are-zero off, a source with exponent 0 and a nonzero fraction is classified as token 6 or 7. With it on, that source is classified as token 2, and the source copy (code 2) yields a zero with the source sign. The destination element is never flushed.
- R7: Control bit 0 raises divide-by-zero on token 2. Invalid is raised by control bit 1 on token 2, bit 2 on token 1, bit 3 on token 4, bit 4 on token 6, bit 5 on token 3 and bit 6 on token 5. Bit 7 has no effect. Only lanes with write-mask bit 1 contribute.
- R8: Both flags are sticky. Once set they stay set until reset, and reset clears them.
- R9: With broadcast on, every lane uses bits [31:0] of the table vector as its table word.
- R10: Results and flags for an input strobed in one cycle appear with the result-valid output high in the next cycle. Result-valid is low in cycles that follow no strobe. Reset clears the result vector, result-valid and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; capture this cycle's result |
| dst_vec | input | 32*LANES | Destination elements (lane i at bits [32i+31:32i]) |
| src_vec | input | 32*LANES | Source elements to classify |
| tbl_vec | input | 32*LANES | Per-lane table words |
| tbl_bcast | input | 1 | Use tbl_vec[31:0] for every lane |
| ctrl_imm | input | 8 | Flag-reporting enables |
| wmask | input | LANES | Per-lane write mask |
| zero_mask | input | 1 | Write +0.0 into masked-off lanes |
| daz | input | 1 | Treat denormal sources as zero |
| out_valid | output | 1 | Result vector valid |
| res_vec | output | 32*LANES | Merged result vector |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_divzero | output | 1 | Sticky divide-by-zero flag |

## Verification
A table word with a different code in every field is applied to sources that cover all eight categories. Because each category then produces a distinct output, a wrong category or wrong field index shows up as a wrong value. Every code from 1 to 15 is replicated across the table against signed sources, to separate the constant values from the sign-following ones. Mask patterns with zero-masking on and off are checked against a zero table, along with denormal sources and destinations under both denormals-are-zero settings. Together these distinguish merging, zeroing, the keep-on-zero-code rule and a flush applied to the wrong operand. Flag runs enable one control bit at a time, place triggering values in masked-off lanes, and send clean inputs after a flag has been set, which checks lane gating, bit mapping and stickiness. Broadcast runs give each lane a different table word so that lane-0 selection is visible.

// File: rtl/fp32_fixup_pkg.sv
package fp32_fixup_pkg;

    localparam int FP_W    = 32;
    localparam int N_TOK   = 8;
    localparam int CODE_W  = 4;
    localparam int TBL_W   = N_TOK * CODE_W;

    typedef enum logic [2:0] {
        TOK_QNAN    = 3'd0,
        TOK_SNAN    = 3'd1,
        TOK_ZERO    = 3'd2,
        TOK_POS_ONE = 3'd3,
        TOK_NEG_INF = 3'd4,
        TOK_POS_INF = 3'd5,
        TOK_NEG     = 3'd6,
        TOK_POS     = 3'd7
    } token_e;

    typedef enum logic [3:0] {
        RSP_KEEP     = 4'd0,
        RSP_DST      = 4'd1,
        RSP_SRC      = 4'd2,
        RSP_QNAN_SRC = 4'd3,
        RSP_DEF_QNAN = 4'd4,
        RSP_NEG_INF  = 4'd5,
        RSP_POS_INF  = 4'd6,
        RSP_SGN_INF  = 4'd7,
        RSP_NEG_ZERO = 4'd8,
        RSP_POS_ZERO = 4'd9,
        RSP_NEG_ONE  = 4'd10,
        RSP_POS_ONE  = 4'd11,
        RSP_HALF     = 4'd12,
        RSP_NINETY   = 4'd13,
        RSP_HALF_PI  = 4'd14,
        RSP_SGN_MAX  = 4'd15
    } resp_e;

    typedef struct packed {
        logic        sign;
        logic [7:0]  expo;
        logic [22:0] frac;
    } fp32_t;

    typedef struct packed {
        logic invalid;
        logic divzero;
    } flags_t;

    localparam fp32_t FP_POS_ONE  = 32'h3F80_0000;
    localparam fp32_t FP_NEG_ONE  = 32'hBF80_0000;
    localparam fp32_t FP_POS_INF  = 32'h7F80_0000;
    localparam fp32_t FP_NEG_INF  = 32'hFF80_0000;
    localparam fp32_t FP_DEF_QNAN = 32'h7FC0_0000;
    localparam fp32_t FP_HALF     = 32'h3F00_0000;
    localparam fp32_t FP_NINETY   = 32'h42B4_0000;
    localparam fp32_t FP_HALF_PI  = 32'h3FC9_0FDB;
    localparam logic [30:0] FP_MAX_MAG = 31'h7F7F_FFFF;

    function automatic resp_e select_code(input logic [TBL_W-1:0] tbl, input token_e tok);
        return resp_e'(tbl[CODE_W*int'(tok) +: CODE_W]);
    endfunction

endpackage

// File: rtl/fixup_classifier.sv
module fixup_classifier
    import fp32_fixup_pkg::*;
(
    input  fp32_t  src,
    input  logic   daz,
    output token_e tok,
    output fp32_t  src_eff
);
    logic exp_max, exp_min, frac_nz;
    logic [N_TOK-1:0] hit;

    assign exp_max = &src.expo;
    assign exp_min = ~|src.expo;
    assign frac_nz = |src.frac;

    always_comb begin
        src_eff = src;
        if (daz && exp_min) src_eff.frac = '0;
    end

    always_comb begin
        hit = '0;
        hit[TOK_QNAN]    = exp_max &  frac_nz &  src.frac[22];
        hit[TOK_SNAN]    = exp_max &  frac_nz & ~src.frac[22];
        hit[TOK_ZERO]    = exp_min & (~frac_nz | daz);
        hit[TOK_POS_ONE] = (src == FP_POS_ONE);
        hit[TOK_NEG_INF] = exp_max & ~frac_nz &  src.sign;
        hit[TOK_POS_INF] = exp_max & ~frac_nz & ~src.sign;
        hit[TOK_NEG]     = ~(|hit[5:0]) &  src.sign;
        hit[TOK_POS]     = ~(|hit[5:0]) & ~src.sign;
    end

    always_comb begin
        tok = TOK_POS;
        for (int t = 0; t < N_TOK; t++) begin
            if (hit[t]) tok = token_e'(t);
        end
    end

    // R1: exactly one category per source value
    always_comb begin
        if (!$isunknown(src) && !$isunknown(daz))
            a_r1_one_token: assert ($onehot(hit));
    end

endmodule

// File: rtl/fixup_lane.sv
module fixup_lane
    import fp32_fixup_pkg::*;
(
    input  fp32_t             dst,
    input  fp32_t             src,
    input  logic [TBL_W-1:0]  tbl,
    input  logic [7:0]        imm,
    input  logic              active,
    input  logic              zero_mask,
    input  logic              daz,
    output fp32_t             res,
    output flags_t            flg
);
    token_e tok;
    fp32_t  src_eff;
    resp_e  code;
    fp32_t  fix_val;
    logic   unused_imm_hi;

    assign unused_imm_hi = imm[7];

    fixup_classifier u_cls (
        .src     (src),
        .daz     (daz),
        .tok     (tok),
        .src_eff (src_eff)
    );

    assign code = select_code(tbl, tok);

    always_comb begin
        unique case (code)
            RSP_KEEP,
            RSP_DST:      fix_val = dst;
            RSP_SRC:      fix_val = src_eff;
            RSP_QNAN_SRC: fix_val = {src_eff.sign, src_eff.expo, 1'b1, src_eff.frac[21:0]};
            RSP_DEF_QNAN: fix_val = FP_DEF_QNAN;
            RSP_NEG_INF:  fix_val = FP_NEG_INF;
            RSP_POS_INF:  fix_val = FP_POS_INF;
            RSP_SGN_INF:  fix_val = {src_eff.sign, FP_POS_INF[30:0]};
            RSP_NEG_ZERO: fix_val = 32'h8000_0000;
            RSP_POS_ZERO: fix_val = 32'h0000_0000;
            RSP_NEG_ONE:  fix_val = FP_NEG_ONE;
            RSP_POS_ONE:  fix_val = FP_POS_ONE;
            RSP_HALF:     fix_val = FP_HALF;
            RSP_NINETY:   fix_val = FP_NINETY;
            RSP_HALF_PI:  fix_val = FP_HALF_PI;
            RSP_SGN_MAX:  fix_val = {src_eff.sign, FP_MAX_MAG};
            default:      fix_val = dst;
        endcase
    end

    always_comb begin
        if (active)         res = fix_val;
        else if (zero_mask) res = '0;
        else                res = dst;
    end

    always_comb begin
        flg.divzero = active & imm[0] & (tok == TOK_ZERO);
        flg.invalid = active & ((imm[1] & (tok == TOK_ZERO))
                              | (imm[2] & (tok == TOK_SNAN))
                              | (imm[3] & (tok == TOK_NEG_INF))
                              | (imm[4] & (tok == TOK_NEG))
                              | (imm[5] & (tok == TOK_POS_ONE))
                              | (imm[6] & (tok == TOK_POS_INF)));
    end

endmodule

// File: rtl/fp32_fixup_unit.sv
module fp32_fixup_unit
    import fp32_fixup_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VEC_W = LANES * FP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] tbl_vec,
    input  logic             tbl_bcast,
    input  logic [7:0]       ctrl_imm,
    input  logic [LANES-1:0] wmask,
    input  logic             zero_mask,
    input  logic             daz,
    output logic             out_valid,
    output logic [VEC_W-1:0] res_vec,
    output logic             flag_invalid,
    output logic             flag_divzero
);
    logic [VEC_W-1:0] lane_res;
    logic [LANES-1:0] lane_inv;
    logic [LANES-1:0] lane_dz;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [TBL_W-1:0] tbl_word;
        fp32_t            res_i;
        flags_t           flg_i;

        assign tbl_word = tbl_bcast ? tbl_vec[TBL_W-1:0] : tbl_vec[i*FP_W +: FP_W];

        fixup_lane u_lane (
            .dst       (fp32_t'(dst_vec[i*FP_W +: FP_W])),
            .src       (fp32_t'(src_vec[i*FP_W +: FP_W])),
            .tbl       (tbl_word),
            .imm       (ctrl_imm),
            .active    (wmask[i]),
            .zero_mask (zero_mask),
            .daz       (daz),
            .res       (res_i),
            .flg       (flg_i)
        );

        assign lane_res[i*FP_W +: FP_W] = res_i;
        assign lane_inv[i] = flg_i.invalid;
        assign lane_dz[i]  = flg_i.divzero;

        // R5: masked-off lane under zero-masking reads back as +0.0
        a_r5_zero_lane: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !wmask[i] && zero_mask) |=> (res_vec[i*FP_W +: FP_W] == '0));

        // R4: masked-off lane under merging keeps the destination element
        a_r4_merge_lane: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !wmask[i] && !zero_mask) |=>
            (res_vec[i*FP_W +: FP_W] == $past(dst_vec[i*FP_W +: FP_W])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            res_vec      <= '0;
            flag_invalid <= 1'b0;
            flag_divzero <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_vec      <= lane_res;
                flag_invalid <= flag_invalid | (|lane_inv);
                flag_divzero <= flag_divzero | (|lane_dz);
            end
        end
    end

    // R10: one-cycle latency of the valid strobe
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: flags never drop without reset
    a_r8_sticky_inv: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |=> flag_invalid);
    a_r8_sticky_dz: assert property (@(posedge clk) disable iff (rst)
        flag_divzero |=> flag_divzero);

    // R7: a flag rises only when an enable bit allowed it
    a_r7_dz_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_divzero) |-> $past(ctrl_imm[0]) && $past(in_valid));
    a_r7_inv_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_invalid) |-> ($past(ctrl_imm[6:1]) != 6'd0) && $past(in_valid));

endmodule

// File: tb/tb_fp32_fixup_unit.sv
module tb_fp32_fixup_unit;
    localparam int N = 4;
    localparam int W = 32 * N;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [W-1:0] dst_vec, src_vec, tbl_vec;
    logic         tbl_bcast;
    logic [7:0]   ctrl_imm;
    logic [N-1:0] wmask;
    logic         zero_mask, daz;
    logic         out_valid;
    logic [W-1:0] res_vec;
    logic         flag_invalid, flag_divzero;

    always #5 clk = ~clk;

    fp32_fixup_unit #(.LANES(N)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .dst_vec(dst_vec), .src_vec(src_vec), .tbl_vec(tbl_vec),
        .tbl_bcast(tbl_bcast), .ctrl_imm(ctrl_imm), .wmask(wmask),
        .zero_mask(zero_mask), .daz(daz), .out_valid(out_valid),
        .res_vec(res_vec), .flag_invalid(flag_invalid), .flag_divzero(flag_divzero)
    );

    typedef struct {
        logic [W-1:0] res;
        logic         inv;
        logic         dz;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    logic acc_inv = 1'b0, acc_dz = 1'b0;
    bit   done = 0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // behavioural reference of one lane
    function automatic logic [31:0] model_lane(
        input logic [31:0] d, input logic [31:0] s, input logic [31:0] t,
        input logic [7:0] imm, input logic act, input logic zm, input logic dzm,
        output logic inv, output logic dz);
        logic [7:0]  e;
        logic [22:0] f;
        logic        sg;
        int          tk;
        logic [3:0]  c;
        logic [31:0] se, r;
        e = s[30:23]; f = s[22:0]; sg = s[31];
        if (dzm && e == 8'h00) f = '0;
        se = {sg, e, f};
        if (e == 8'hFF && f != 0)      tk = f[22] ? 0 : 1;
        else if (e == 8'h00 && f == 0) tk = 2;
        else if (s == 32'h3F800000)    tk = 3;
        else if (e == 8'hFF)           tk = sg ? 4 : 5;
        else                           tk = sg ? 6 : 7;
        c = t[4*tk +: 4];
        case (c)
            4'd0, 4'd1: r = d;
            4'd2:  r = se;
            4'd3:  r = se | 32'h0040_0000;
            4'd4:  r = 32'h7FC0_0000;
            4'd5:  r = 32'hFF80_0000;
            4'd6:  r = 32'h7F80_0000;
            4'd7:  r = sg ? 32'hFF80_0000 : 32'h7F80_0000;
            4'd8:  r = 32'h8000_0000;
            4'd9:  r = 32'h0000_0000;
            4'd10: r = 32'hBF80_0000;
            4'd11: r = 32'h3F80_0000;
            4'd12: r = 32'h3F00_0000;
            4'd13: r = 32'h42B4_0000;
            4'd14: r = 32'h3FC9_0FDB;
            default: r = {sg, 31'h7F7F_FFFF};
        endcase
        if (!act) r = zm ? 32'h0 : d;
        dz  = act && imm[0] && tk == 2;
        inv = act && ((imm[1] && tk == 2) || (imm[2] && tk == 1) || (imm[3] && tk == 4) ||
                      (imm[4] && tk == 6) || (imm[5] && tk == 3) || (imm[6] && tk == 5));
        return r;
    endfunction

    task automatic send(input string tag, input logic [W-1:0] d, input logic [W-1:0] s,
                        input logic [W-1:0] t, input logic bc, input logic [7:0] imm,
                        input logic [N-1:0] m, input logic zm, input logic dzm);
        exp_t it;
        @(negedge clk);
        dst_vec = d; src_vec = s; tbl_vec = t; tbl_bcast = bc; ctrl_imm = imm;
        wmask = m; zero_mask = zm; daz = dzm; in_valid = 1'b1;
        for (int i = 0; i < N; i++) begin
            logic li, ld;
            it.res[32*i +: 32] = model_lane(d[32*i +: 32], s[32*i +: 32],
                                            bc ? t[31:0] : t[32*i +: 32],
                                            imm, m[i], zm, dzm, li, ld);
            acc_inv = acc_inv | li;
            acc_dz  = acc_dz | ld;
        end
        it.inv = acc_inv; it.dz = acc_dz; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 actual=valid_without_input expected=idle");
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " result"}, res_vec, e.res);
                check({e.tag, " R7 invalid flag"}, W'(flag_invalid), W'(e.inv));
                check({e.tag, " R7 divzero flag"}, W'(flag_divzero), W'(e.dz));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        acc_inv = 1'b0; acc_dz = 1'b0;
        check("R10 reset valid", W'(out_valid), W'(0));
        check("R10 reset result", res_vec, '0);
        check("R8 reset clears flags", W'({flag_invalid, flag_divzero}), W'(0));
    endtask

    function automatic logic [W-1:0] rep(input logic [31:0] x);
        return {N{x}};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [W-1:0] DST = {32'h4120_0000, 32'hC2C8_0000, 32'h0000_0007, 32'h3E80_0000};

    initial begin
        rst = 1'b1; in_valid = 1'b0; dst_vec = '0; src_vec = '0; tbl_vec = '0;
        tbl_bcast = 1'b0; ctrl_imm = '0; wmask = '0; zero_mask = 1'b0; daz = 1'b0;
        repeat (3) @(posedge clk);
        do_reset();

        // R1: distinct code per token reveals the category
        send("R1 tokens nan/zero", DST,
             {32'h7FC0_1234, 32'h7F80_0001, 32'h8000_0000, 32'h3F80_0000},
             rep(32'hEDCB_A965), 1'b0, 8'h00, 4'hF, 1'b0, 1'b0);
        send("R1 tokens inf/other", DST,
             {32'hFF80_0000, 32'h7F80_0000, 32'hC000_0000, 32'h3F80_0001},
             rep(32'hEDCB_A965), 1'b0, 8'h00, 4'hF, 1'b0, 1'b0);
        send("R1 tokens swapped table", DST,
             {32'hFFC0_0000, 32'hFF80_0003, 32'h0000_0000, 32'hBF80_0000},
             rep(32'h5A9B_CDE6), 1'b0, 8'h00, 4'hF, 1'b0, 1'b0);

        // R3: every code replicated over all fields
        for (int c = 1; c < 16; c++) begin
            send($sformatf("R3 code %0d", c), DST,
                 {32'hC040_0000, 32'h7F80_0005, 32'h4049_0FDB, 32'hFF80_0000},
                 rep({8{c[3:0]}}), 1'b0, 8'h00, 4'hF, 1'b0, 1'b0);
        end

        // R2: zero code keeps destination
        send("R2 keep on code 0", DST,
             {32'h7FC0_0000, 32'h0000_0000, 32'hFF80_0000, 32'h4000_0000},
             '0, 1'b0, 8'h00, 4'hF, 1'b0, 1'b0);

        // R4/R5: mask merging and zeroing
        send("R4 merge masked lanes", DST, rep(32'h0000_0000), rep(32'h9999_9999),
             1'b0, 8'h00, 4'b0101, 1'b0, 1'b0);
        send("R5 zero masked lanes", DST, rep(32'h0000_0000), rep(32'h9999_9999),
             1'b0, 8'h00, 4'b1010, 1'b1, 1'b0);
        send("R5 all masked zeroing", DST, rep(32'h7F80_0000), rep(32'hFFFF_FFFF),
             1'b0, 8'h00, 4'b0000, 1'b1, 1'b0);

        // R6: denormals with daz off / on; destination denormal untouched
        send("R6 daz off", DST, {32'h0000_0001, 32'h8000_0005, 32'h0040_0000, 32'h807F_FFFF},
             rep(32'h9A2B_CDE2), 1'b0, 8'h00, 4'hF, 1'b0, 1'b0);
        send("R6 daz on", DST, {32'h0000_0001, 32'h8000_0005, 32'h0040_0000, 32'h807F_FFFF},
             rep(32'h9A2B_CDE9), 1'b0, 8'h00, 4'hF, 1'b0, 1'b1);
        send("R6 daz on src copy", DST, {32'h0000_0001, 32'h8000_0005, 32'h0040_0000, 32'h807F_FFFF},
             rep(32'h2222_2222), 1'b0, 8'h00, 4'hF, 1'b0, 1'b1);
        send("R6 dst not flushed", {32'h0000_0003, 32'h8000_0009, 32'h0000_0001, 32'h0070_0000},
             rep(32'h0000_0001), rep(32'h1111_1111), 1'b0, 8'h00, 4'b0011, 1'b0, 1'b1);
        idle(3);
        check("R10 idle valid low", W'(out_valid), W'(0));

        // R7: triggering values only in masked-off lanes give no flag
        do_reset();
        send("R7 inactive lanes no flag", DST,
             {32'h0000_0000, 32'h7F80_0001, 32'hFF80_0000, 32'hC000_0000},
             '0, 1'b0, 8'hFF, 4'h0, 1'b0, 1'b0);
        send("R7 bit7 only no flag", DST, rep(32'h0000_0000), '0, 1'b0, 8'h80, 4'hF, 1'b0, 1'b0);
        send("R7 daz off denormal no flag", DST, rep(32'h0000_0001), '0, 1'b0, 8'h03, 4'hF, 1'b0, 1'b0);
        idle(2);

        for (int b = 0; b < 7; b++) begin
            do_reset();
            send($sformatf("R7 enable bit %0d miss", b), DST,
                 {32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000},
                 '0, 1'b0, 8'(1 << b), 4'hF, 1'b0, 1'b0);
            send($sformatf("R7 enable bit %0d hit", b), DST,
                 {32'h0000_0000, 32'h7F80_0001, 32'hFF80_0000, 32'hC000_0000},
                 '0, 1'b0, 8'(1 << b), 4'b1111, 1'b0, 1'b0);
            send($sformatf("R7 enable bit %0d more", b), DST,
                 {32'h3F80_0000, 32'h7F80_0000, 32'h8000_0001, 32'h4000_0000},
                 '0, 1'b0, 8'(1 << b), 4'b1111, 1'b0, 1'b1);
            // R8: clean input keeps flags set
            send($sformatf("R8 sticky after bit %0d", b), DST, rep(32'h4000_0000),
                 '0, 1'b0, 8'h00, 4'hF, 1'b0, 1'b0);
            idle(2);
        end

        // R9: broadcast uses lane-0 table word
        do_reset();
        send("R9 broadcast on", DST, rep(32'h0000_0000),
             {32'h0000_0600, 32'h0000_0B00, 32'h0000_0500, 32'h0000_0D00},
             1'b1, 8'h00, 4'hF, 1'b0, 1'b0);
        send("R9 broadcast off", DST, rep(32'h0000_0000),
             {32'h0000_0600, 32'h0000_0B00, 32'h0000_0500, 32'h0000_0D00},
             1'b0, 8'h00, 4'hF, 1'b0, 1'b0);
        idle(3);
        check("R10 queue drained", W'(q.size()), W'(0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule